// File: doc/BRIEF.md
# PLL Loop Supervisor with Noise Holdover

This block is a digital supervisor that sits beside the phase-frequency detector of a phase-locked loop. The reference and divided-feedback inputs reach it as single-cycle edge pulses that are already synchronised to a fast system clock. It measures the spacing of those pulses in system-clock cycles and sorts the loop into one of three conditions: capturing, locked on a clean reference, or locked while the reference is disturbed.

From that condition it drives a loop-filter bandwidth select, which is wide while capturing and narrow once locked. It also drives an arming signal that makes noise detection effective only after lock, and a hold output. The block contains its own three-state edge detector, and its up and down correction pulses pass straight through to the charge pump. While hold is asserted, both pulses are forced low, so the loop filter sees no correction and keeps its voltage until the disturbance has passed.

Tolerances and the hold limit are inputs, so firmware-free system logic can tie them off per product.

Top module: `pll_supervisor`

## Requirements
- R1: `rst` is synchronous and active-high. In the cycle after a clock edge with `rst` high, `bw_narrow_o`, `nd_arm_o`, `hold_o`, `up_o` and `dn_o` are all 0, and every period measurement and qualification count restarts.
- R2: In the capture condition, the loop is declared locked after 8 consecutive reference periods, each within `tol_i` cycles of the latest measured feedback period. Lock sets `bw_narrow_o` = 1 (narrow) and `nd_arm_o` = 1. Fewer than 8 matching periods never give lock.
- R3: While the reference and feedback periods differ by more than `tol_i`, the block stays in capture with `bw_narrow_o` = 0 and `nd_arm_o` = 0.
- R4: While `hold_o` = 1, `up_o` and `dn_o` are both 0.
- R5: In the locked condition, a measured reference period that differs from the last accepted reference period by more than `noise_thr_i` asserts `hold_o`. `bw_narrow_o` stays 1.
- R6: In hold, 4 consecutive reference periods within `noise_thr_i` of the last accepted period release `hold_o`. Correction resumes and the bandwidth stays narrow.
- R7: Hold lasts at most `hold_max_i` consecutive cycles. When that limit is reached, the block returns to capture with `bw_narrow_o` = 0 and `hold_o` = 0.
- R8: In the locked condition, 8 consecutive feedback periods that each differ from the accepted reference period by more than `tol_i` return the block to capture. Fewer such periods keep lock.
- R9: In capture, disturbed reference pulses never assert `hold_o`.
- R10: The edge detector keeps an up flag and a down flag. A reference pulse sets up and a feedback pulse sets down. When both would be set, both clear instead. The flags are registered and appear on `up_o`/`dn_o` one cycle after the pulse, and they are never both 1.
- R11: The first edge pulse on an input after reset gives no period measurement. A period is the number of system-clock cycles from one pulse to the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active-high |
| ref_edge_i | input | 1 | One-cycle pulse per reference rising edge |
| fb_edge_i | input | 1 | One-cycle pulse per divided-feedback rising edge |
| tol_i | input | CNT_W | Lock tolerance in system-clock cycles |
| noise_thr_i | input | CNT_W | Noise threshold in system-clock cycles |
| hold_max_i | input | TO_W | Maximum hold duration in cycles |
| bw_narrow_o | output | 1 | 1 selects the narrow loop-filter bandwidth |
| nd_arm_o | output | 1 | 1 when noise detection is effective |
| hold_o | output | 1 | 1 while corrections are frozen |
| up_o | output | 1 | Charge-pump up pulse |
| dn_o | output | 1 | Charge-pump down pulse |

## Verification
The hardest state to reach from the ports is a long hold that ends by timeout. Reaching it needs a qualified lock first, then a burst of short reference periods that stays inside the noise window for longer than the hold limit. It must also never give four clean periods in a row. The bench runs free-running pulse generators with settable periods and a noise mode that fires the reference every third cycle. It locks the loop, keeps the noise mode on past the limit, and then keeps the noise on in capture to show that hold stays low. The same generators also move the feedback period away from the reference to reach loss of lock.

// File: rtl/pll_sup_pkg.sv
package pll_sup_pkg;

    typedef enum logic [1:0] {
        ST_CAPTURE = 2'd0,
        ST_LOCKED  = 2'd1,
        ST_HOLD    = 2'd2
    } sup_state_e;

    typedef struct packed {
        logic up;
        logic dn;
    } pfd_flags_t;

    localparam int DEF_CNT_W   = 16;
    localparam int DEF_TO_W    = 16;
    localparam int DEF_LOCK_N  = 8;
    localparam int DEF_CLEAR_N = 4;
    localparam int DEF_LOSS_N  = 8;

endpackage

// File: rtl/pll_sup_period_meter.sv
module pll_sup_period_meter #(
    parameter int CNT_W = pll_sup_pkg::DEF_CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             edge_i,
    output logic [CNT_W-1:0] period_o,
    output logic             valid_o
);
    localparam logic [CNT_W-1:0] CNT_MAX = '1;
    localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

    logic [CNT_W-1:0] span_q;
    logic             seen_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            span_q   <= '0;
            seen_q   <= 1'b0;
            period_o <= '0;
            valid_o  <= 1'b0;
        end else begin
            valid_o <= 1'b0;
            if (edge_i) begin
                span_q   <= CNT_ONE;
                seen_q   <= 1'b1;
                period_o <= span_q;
                valid_o  <= seen_q;
            end else if (span_q != CNT_MAX) begin
                span_q <= span_q + CNT_ONE;
            end
        end
    end
endmodule

// File: rtl/pll_sup_pfd.sv
module pll_sup_pfd
    import pll_sup_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       ref_i,
    input  logic       fb_i,
    output pfd_flags_t flags_o
);
    pfd_flags_t nxt;

    always_comb begin
        nxt.up = flags_o.up | ref_i;
        nxt.dn = flags_o.dn | fb_i;
        if (nxt.up && nxt.dn) begin
            nxt = '0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            flags_o <= '0;
        end else begin
            flags_o <= nxt;
        end
    end
endmodule

// File: rtl/pll_sup_fsm.sv
module pll_sup_fsm
    import pll_sup_pkg::*;
#(
    parameter int CNT_W   = DEF_CNT_W,
    parameter int TO_W    = DEF_TO_W,
    parameter int LOCK_N  = DEF_LOCK_N,
    parameter int CLEAR_N = DEF_CLEAR_N,
    parameter int LOSS_N  = DEF_LOSS_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_valid_i,
    input  logic [CNT_W-1:0] ref_per_i,
    input  logic             fb_valid_i,
    input  logic [CNT_W-1:0] fb_per_i,
    input  logic [CNT_W-1:0] tol_i,
    input  logic [CNT_W-1:0] noise_thr_i,
    input  logic [TO_W-1:0]  hold_max_i,
    output sup_state_e       state_o
);
    localparam int LK_W = $clog2(LOCK_N + 1);
    localparam int CL_W = $clog2(CLEAR_N + 1);
    localparam int LS_W = $clog2(LOSS_N + 1);
    localparam logic [LK_W-1:0] LK_LAST = LK_W'(LOCK_N - 1);
    localparam logic [CL_W-1:0] CL_LAST = CL_W'(CLEAR_N - 1);
    localparam logic [LS_W-1:0] LS_LAST = LS_W'(LOSS_N - 1);

    function automatic logic [CNT_W-1:0] absd(input logic [CNT_W-1:0] a,
                                              input logic [CNT_W-1:0] b);
        return (a >= b) ? (a - b) : (b - a);
    endfunction

    logic [CNT_W-1:0] good_ref_q, fb_last_q;
    logic             fb_have_q;
    logic [LK_W-1:0]  match_q;
    logic [CL_W-1:0]  clean_q;
    logic [LS_W-1:0]  drift_q;
    logic [TO_W-1:0]  hold_tmr_q;

    logic [CNT_W-1:0] d_ref_fb, d_ref_good, d_fb_good;
    logic [TO_W:0]    tmr_next;
    logic             hold_expired;

    assign d_ref_fb     = absd(ref_per_i, fb_last_q);
    assign d_ref_good   = absd(ref_per_i, good_ref_q);
    assign d_fb_good    = absd(fb_per_i, good_ref_q);
    assign tmr_next     = {1'b0, hold_tmr_q} + (TO_W+1)'(1);
    assign hold_expired = (tmr_next >= {1'b0, hold_max_i});

    always_ff @(posedge clk) begin
        if (rst) begin
            state_o    <= ST_CAPTURE;
            good_ref_q <= '0;
            fb_last_q  <= '0;
            fb_have_q  <= 1'b0;
            match_q    <= '0;
            clean_q    <= '0;
            drift_q    <= '0;
            hold_tmr_q <= '0;
        end else begin
            if (fb_valid_i) begin
                fb_last_q <= fb_per_i;
                fb_have_q <= 1'b1;
            end
            case (state_o)
                ST_CAPTURE: begin
                    hold_tmr_q <= '0;
                    drift_q    <= '0;
                    clean_q    <= '0;
                    if (ref_valid_i) begin
                        if (fb_have_q && (d_ref_fb <= tol_i)) begin
                            if (match_q == LK_LAST) begin
                                state_o    <= ST_LOCKED;
                                good_ref_q <= ref_per_i;
                                match_q    <= '0;
                            end else begin
                                match_q <= match_q + 1'b1;
                            end
                        end else begin
                            match_q <= '0;
                        end
                    end
                end
                ST_LOCKED: begin
                    if (ref_valid_i) begin
                        if (d_ref_good > noise_thr_i) begin
                            state_o    <= ST_HOLD;
                            hold_tmr_q <= '0;
                            clean_q    <= '0;
                        end else begin
                            good_ref_q <= ref_per_i;
                        end
                    end
                    if (fb_valid_i) begin
                        if (d_fb_good > tol_i) begin
                            if (drift_q == LS_LAST) begin
                                state_o <= ST_CAPTURE;
                                drift_q <= '0;
                                match_q <= '0;
                            end else begin
                                drift_q <= drift_q + 1'b1;
                            end
                        end else begin
                            drift_q <= '0;
                        end
                    end
                end
                ST_HOLD: begin
                    hold_tmr_q <= tmr_next[TO_W-1:0];
                    if (ref_valid_i) begin
                        if (d_ref_good <= noise_thr_i) begin
                            if (clean_q == CL_LAST) begin
                                state_o <= ST_LOCKED;
                                clean_q <= '0;
                                drift_q <= '0;
                            end else begin
                                clean_q <= clean_q + 1'b1;
                            end
                        end else begin
                            clean_q <= '0;
                        end
                    end
                    if (hold_expired) begin
                        state_o <= ST_CAPTURE;
                        match_q <= '0;
                    end
                end
                default: state_o <= ST_CAPTURE;
            endcase
        end
    end
endmodule

// File: rtl/pll_supervisor.sv
module pll_supervisor
    import pll_sup_pkg::*;
#(
    parameter int CNT_W   = DEF_CNT_W,
    parameter int TO_W    = DEF_TO_W,
    parameter int LOCK_N  = DEF_LOCK_N,
    parameter int CLEAR_N = DEF_CLEAR_N,
    parameter int LOSS_N  = DEF_LOSS_N
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ref_edge_i,
    input  logic             fb_edge_i,
    input  logic [CNT_W-1:0] tol_i,
    input  logic [CNT_W-1:0] noise_thr_i,
    input  logic [TO_W-1:0]  hold_max_i,
    output logic             bw_narrow_o,
    output logic             nd_arm_o,
    output logic             hold_o,
    output logic             up_o,
    output logic             dn_o
);
    localparam int N_IN = 2;

    logic [N_IN-1:0]  edge_vec;
    logic [N_IN-1:0]  valid_vec;
    logic [CNT_W-1:0] per_vec [N_IN];
    sup_state_e       state;
    pfd_flags_t       flags;

    assign edge_vec = {fb_edge_i, ref_edge_i};

    for (genvar g = 0; g < N_IN; g++) begin : g_meter
        pll_sup_period_meter #(.CNT_W(CNT_W)) u_meter (
            .clk      (clk),
            .rst      (rst),
            .edge_i   (edge_vec[g]),
            .period_o (per_vec[g]),
            .valid_o  (valid_vec[g])
        );
    end

    pll_sup_fsm #(
        .CNT_W   (CNT_W),
        .TO_W    (TO_W),
        .LOCK_N  (LOCK_N),
        .CLEAR_N (CLEAR_N),
        .LOSS_N  (LOSS_N)
    ) u_fsm (
        .clk         (clk),
        .rst         (rst),
        .ref_valid_i (valid_vec[0]),
        .ref_per_i   (per_vec[0]),
        .fb_valid_i  (valid_vec[1]),
        .fb_per_i    (per_vec[1]),
        .tol_i       (tol_i),
        .noise_thr_i (noise_thr_i),
        .hold_max_i  (hold_max_i),
        .state_o     (state)
    );

    pll_sup_pfd u_pfd (
        .clk     (clk),
        .rst     (rst),
        .ref_i   (ref_edge_i),
        .fb_i    (fb_edge_i),
        .flags_o (flags)
    );

    assign bw_narrow_o = (state != ST_CAPTURE);
    assign nd_arm_o    = (state != ST_CAPTURE);
    assign hold_o      = (state == ST_HOLD);
    assign up_o        = flags.up & ~hold_o;
    assign dn_o        = flags.dn & ~hold_o;
endmodule

// File: rtl/pll_supervisor_chk.sv
module pll_supervisor_chk #(
    parameter int TO_W = pll_sup_pkg::DEF_TO_W
) (
    input logic            clk,
    input logic            rst,
    input logic [TO_W-1:0] hold_max_i,
    input logic            bw_narrow_o,
    input logic            hold_o,
    input logic            up_o,
    input logic            dn_o
);
    logic [TO_W:0] hold_len;

    always_ff @(posedge clk) begin
        if (rst || !hold_o) begin
            hold_len <= '0;
        end else if (hold_len != '1) begin
            hold_len <= hold_len + 1'b1;
        end
    end

    a_r1_reset_clears: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!hold_o && !bw_narrow_o && !up_o && !dn_o));

    a_r4_hold_blocks_pulses: assert property (@(posedge clk) disable iff (rst)
        hold_o |-> (!up_o && !dn_o));

    a_r10_pfd_not_both: assert property (@(posedge clk) disable iff (rst)
        !(up_o && dn_o));

    a_r9_hold_needs_lock: assert property (@(posedge clk) disable iff (rst)
        $rose(hold_o) |-> $past(bw_narrow_o));

    a_r7_hold_bounded: assert property (@(posedge clk) disable iff (rst)
        hold_len <= {1'b0, hold_max_i});

    a_r5_hold_keeps_narrow: assert property (@(posedge clk) disable iff (rst)
        hold_o |-> bw_narrow_o);
endmodule

bind pll_supervisor pll_supervisor_chk #(.TO_W(TO_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .hold_max_i  (hold_max_i),
    .bw_narrow_o (bw_narrow_o),
    .hold_o      (hold_o),
    .up_o        (up_o),
    .dn_o        (dn_o)
);

// File: tb/tb_pll_supervisor.sv
module tb_pll_supervisor;
    localparam int CNT_W = 16;
    localparam int TO_W  = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ref_edge, fb_edge;
    logic [CNT_W-1:0] tol = CNT_W'(2);
    logic [CNT_W-1:0] thr = CNT_W'(10);
    logic [TO_W-1:0]  hmax = TO_W'(1000);
    logic bw_narrow, nd_arm, hold, up, dn;

    logic use_gen = 1'b0;
    logic tab_ref = 1'b0, tab_fb = 1'b0;
    logic gen_ref = 1'b0, gen_fb = 1'b0;
    logic noise_on = 1'b0;
    int   ref_per_t = 40;
    int   fb_per_t  = 40;
    int   rc = 0;
    int   fc = 10;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #10 clk = ~clk;

    assign ref_edge = use_gen ? gen_ref : tab_ref;
    assign fb_edge  = use_gen ? gen_fb  : tab_fb;

    pll_supervisor dut (
        .clk         (clk),
        .rst         (rst),
        .ref_edge_i  (ref_edge),
        .fb_edge_i   (fb_edge),
        .tol_i       (tol),
        .noise_thr_i (thr),
        .hold_max_i  (hmax),
        .bw_narrow_o (bw_narrow),
        .nd_arm_o    (nd_arm),
        .hold_o      (hold),
        .up_o        (up),
        .dn_o        (dn)
    );

    always @(negedge clk) begin
        if (use_gen) begin
            if (rc + 1 >= (noise_on ? 3 : ref_per_t)) begin
                gen_ref <= 1'b1;
                rc <= 0;
            end else begin
                gen_ref <= 1'b0;
                rc <= rc + 1;
            end
            if (fc + 1 >= fb_per_t) begin
                gen_fb <= 1'b1;
                fc <= 0;
            end else begin
                gen_fb <= 1'b0;
                fc <= fc + 1;
            end
        end
    end

    // {ref, fb, expected up, expected dn}
    localparam logic [3:0] PFD_TAB [10] = '{
        4'b1010, 4'b0010, 4'b0100, 4'b0101, 4'b0001,
        4'b1000, 4'b1100, 4'b1010, 4'b1100, 4'b0000
    };

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic cyc(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        summary();
    end

    initial begin
        int bad;
        // R1: reset state
        cyc(5);
        check({bw_narrow, nd_arm, hold, up, dn} == 5'b0, "R1 reset outputs",
              int'({bw_narrow, nd_arm, hold, up, dn}), 0);
        rst = 1'b0;

        // R10: edge detector table
        for (int i = 0; i < 10; i++) begin
            tab_ref = PFD_TAB[i][3];
            tab_fb  = PFD_TAB[i][2];
            @(negedge clk);
            check({up, dn} == PFD_TAB[i][1:0], "R10 pfd vector",
                  int'({up, dn}), int'(PFD_TAB[i][1:0]));
        end
        tab_ref = 1'b0;
        tab_fb  = 1'b0;

        // R3 and R11: mismatched periods never lock
        fb_per_t = 46;
        use_gen  = 1'b1;
        cyc(1000);
        check(!bw_narrow && !nd_arm, "R3 stays in capture", int'(bw_narrow), 0);

        // R2: within tolerance, needs 8 periods
        fb_per_t = 41;
        cyc(200);
        check(!bw_narrow, "R2 too few periods", int'(bw_narrow), 0);
        cyc(600);
        check(bw_narrow && nd_arm, "R2 lock narrow and armed",
              int'({bw_narrow, nd_arm}), 3);
        fb_per_t = 40;
        cyc(200);

        // R5: noise after lock asserts hold
        noise_on = 1'b1;
        cyc(30);
        check(hold, "R5 hold on noise", int'(hold), 1);
        check(bw_narrow, "R5 bandwidth narrow in hold", int'(bw_narrow), 1);
        // R4: no correction in hold
        bad = 0;
        for (int i = 0; i < 120; i++) begin
            @(negedge clk);
            if (up || dn) bad++;
        end
        check(bad == 0, "R4 pulses frozen", bad, 0);

        // R6: noise gone, hold releases
        noise_on = 1'b0;
        cyc(360);
        check(!hold, "R6 hold released", int'(hold), 0);
        check(bw_narrow, "R6 still narrow", int'(bw_narrow), 1);
        bad = 0;
        for (int i = 0; i < 200; i++) begin
            @(negedge clk);
            if (up || dn) bad++;
        end
        check(bad > 0, "R6 correction resumed", bad, 1);

        // R7: long noise hits the hold limit
        noise_on = 1'b1;
        cyc(1200);
        check(!bw_narrow && !hold && !nd_arm, "R7 timeout to capture",
              int'({bw_narrow, hold, nd_arm}), 0);
        // R9: noise ignored in capture
        bad = 0;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (hold) bad++;
        end
        check(bad == 0, "R9 no hold in capture", bad, 0);
        noise_on = 1'b0;

        cyc(800);
        check(bw_narrow, "R2 relock", int'(bw_narrow), 1);

        // R8: feedback drift loses lock
        fb_per_t = 50;
        cyc(120);
        check(bw_narrow, "R8 brief drift keeps lock", int'(bw_narrow), 1);
        cyc(600);
        check(!bw_narrow && !hold, "R8 drift to capture",
              int'({bw_narrow, hold}), 0);

        // R1: reset while locked
        fb_per_t = 40;
        cyc(800);
        check(bw_narrow, "R1 locked before reset", int'(bw_narrow), 1);
        rst = 1'b1;
        cyc(1);
        check({bw_narrow, nd_arm, hold, up, dn} == 5'b0, "R1 reset mid-lock",
              int'({bw_narrow, nd_arm, hold, up, dn}), 0);
        rst = 1'b0;
        cyc(2);
        summary();
    end
endmodule